// File: doc/BRIEF.md
# Single-Precision to Unsigned Integer Truncating Converter

This block turns a 32-bit IEEE 754 single-precision operand into a 32-bit unsigned integer. It always rounds toward zero, so any fraction is dropped. Along with the integer it reports two exception flags, invalid and inexact. It also gives a one-bit instruction for the processor's floating-point status word. Either the raised flags are to be merged into the status word, or the sticky status is to be cleared because nothing was raised.

The block has a small pipeline with one stage. An operand offered with `src_vld` high is taken at the rising clock edge. Its result, flags and status instruction show up on the outputs for the following cycle, framed by `res_vld`. A two-state machine frames the output. In state `ST_IDLE` no result is shown. In state `ST_EMIT` a result is shown. The transition `take` (any state to `ST_EMIT`) fires on every cycle where `src_vld` is high. The transition `drain` (any state to `ST_IDLE`) fires on every cycle where `src_vld` is low. Synchronous reset forces `ST_IDLE`.

The special cases are resolved in a fixed order. NaN comes first. Then any negative operand other than -0. Then overflow or +infinity. Last comes ordinary truncation.

Top module: `f2u_trunc_conv`

## Requirements
- R1: A positive operand below 2^32 produces its integer part exactly. Examples: 1.0 gives 1, 100.0 gives 0x64, 2^31 gives 0x80000000, and 0x4F7FFFFF (2^32-256) gives 0xFFFFFF00. These raise no flag when no fraction is dropped.
- R2: A positive operand whose dropped fraction is nonzero raises inexact and not invalid. This includes values below 1.0 and subnormals, which give 0 (for example 0x3F000000 and 0x00000001), and 0x40490FDB, which gives 3.
- R3: A NaN operand gives result 0 with invalid alone. NaN means exponent field all ones and fraction nonzero, quiet or signalling, of either sign.
- R4: A negative operand other than -0 gives result 0 with invalid alone and inexact cleared. This covers -0.5, negative subnormals, -100.0 and -infinity.
- R5: +0 (0x00000000) and -0 (0x80000000) both give result 0 with no flag raised.
- R6: A positive operand of 2^32 or more, or +infinity, gives 0xFFFFFFFF with invalid alone.
- R7: Invalid and inexact are never reported high together.
- R8: While `res_vld` is high, `flag_wr` is high exactly when a flag is raised, and `stat_clr` is high exactly when none is. Both are low while `res_vld` is low.
- R9: `res_vld` is high in the cycle after each cycle where `src_vld` is high, and low after each cycle where it is low. Back-to-back operands give back-to-back results.
- R10: `rst_n` low at a rising edge forces `res_vld` low in the next cycle, even when `src_vld` was high at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| src_vld | input | 1 | Operand present this cycle |
| src_op | input | 32 | Single-precision operand |
| res_vld | output | 1 | Result present this cycle |
| res_int | output | 32 | Truncated unsigned integer |
| flg_invalid | output | 1 | Invalid-operation flag |
| flg_inexact | output | 1 | Inexact flag |
| flag_wr | output | 1 | Merge the raised flags into the status word |
| stat_clr | output | 1 | Clear the sticky floating-point status |

## Verification
The bench builds the block with its default field widths: 8 exponent bits, 23 fraction bits and a 32-bit result. With these widths the exact saturation edge between 0x4F7FFFFF and 0x4F800000 can be probed. So can the subnormal and below-one region and both NaN encodings. Random operands draw exponents in a window around the bias and the overflow point. This exercises every barrel-shift distance, together with sticky fraction bits, against a model in the bench.

// File: rtl/f2u_pkg.sv
package f2u_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } f2u_state_e;

    typedef struct packed {
        logic invalid;
        logic inexact;
    } f2u_flags_t;

endpackage

// File: rtl/f2u_decode.sv
module f2u_decode #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    parameter int OUT_W  = 32
) (
    input  logic [EXP_W+FRAC_W:0]       op,
    output logic                        sign,
    output logic                        is_nan,
    output logic                        is_inf,
    output logic                        is_zero,
    output logic                        below_one,
    output logic                        too_big,
    output logic [FRAC_W:0]             sig,
    output logic [$clog2(OUT_W)-1:0]    shamt
);
    localparam int SH_BITS = $clog2(OUT_W);
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam logic signed [EXP_W+1:0] BIAS_V = (EXP_W+2)'(BIAS);
    localparam logic signed [EXP_W+1:0] OUT_V  = (EXP_W+2)'(OUT_W);

    logic [EXP_W-1:0]        exp_f;
    logic [FRAC_W-1:0]       frac_f;
    logic [EXP_W-1:0]        exp_eff;
    logic                    exp_ones;
    logic                    exp_zero;
    logic signed [EXP_W+1:0] ue;

    always_comb begin
        sign     = op[EXP_W+FRAC_W];
        exp_f    = op[EXP_W+FRAC_W-1:FRAC_W];
        frac_f   = op[FRAC_W-1:0];
        exp_ones = &exp_f;
        exp_zero = ~|exp_f;
        is_nan   = exp_ones && (frac_f != '0);
        is_inf   = exp_ones && (frac_f == '0);
        is_zero  = exp_zero && (frac_f == '0);
        // subnormals share the minimum exponent and lose the hidden bit
        exp_eff  = exp_zero ? EXP_W'(1) : exp_f;
        sig      = {~exp_zero, frac_f};
        ue       = $signed({2'b00, exp_eff}) - BIAS_V;
        below_one = ue < 0;
        too_big   = !below_one && (ue >= OUT_V);
        shamt     = ue[SH_BITS-1:0];
    end

endmodule

// File: rtl/f2u_align.sv
module f2u_align #(
    parameter int FRAC_W = 23,
    parameter int OUT_W  = 32
) (
    input  logic [FRAC_W:0]          sig,
    input  logic [$clog2(OUT_W)-1:0] shamt,
    output logic [OUT_W-1:0]         int_part,
    output logic                     sticky
);
    localparam int SH_BITS = $clog2(OUT_W);
    localparam int SIG_W   = FRAC_W + 1;
    localparam int SH_W    = SIG_W + OUT_W - 1;

    logic [SH_W-1:0] stage [0:SH_BITS];

    assign stage[0] = {{(OUT_W-1){1'b0}}, sig};

    // logarithmic left shifter: stage k moves by 2^k when shamt[k] is set
    for (genvar k = 0; k < SH_BITS; k++) begin : g_stage
        assign stage[k+1] = shamt[k] ? (stage[k] << (1 << k)) : stage[k];
    end

    assign int_part = stage[SH_BITS][SH_W-1:FRAC_W];
    assign sticky   = |stage[SH_BITS][FRAC_W-1:0];

endmodule

// File: rtl/f2u_resolve.sv
module f2u_resolve #(
    parameter int OUT_W = 32
) (
    input  logic               sign,
    input  logic               is_nan,
    input  logic               is_inf,
    input  logic               is_zero,
    input  logic               below_one,
    input  logic               too_big,
    input  logic [OUT_W-1:0]   int_part,
    input  logic               sticky,
    output logic [OUT_W-1:0]   result,
    output f2u_pkg::f2u_flags_t flags
);
    always_comb begin
        result        = '0;
        flags.invalid = 1'b0;
        flags.inexact = 1'b0;
        if (is_nan) begin
            flags.invalid = 1'b1;
        end else if (sign && !is_zero) begin
            flags.invalid = 1'b1;
        end else if (is_inf || too_big) begin
            result        = '1;
            flags.invalid = 1'b1;
        end else if (is_zero) begin
            result = '0;
        end else if (below_one) begin
            flags.inexact = 1'b1;
        end else begin
            result        = int_part;
            flags.inexact = sticky;
        end
    end

    always_comb begin
        assert (!(flags.invalid && flags.inexact))
            else $error("p_flag_excl_r7: invalid and inexact together");
    end

endmodule

// File: rtl/f2u_trunc_conv.sv
module f2u_trunc_conv #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    parameter int OUT_W  = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   src_vld,
    input  logic [EXP_W+FRAC_W:0]  src_op,
    output logic                   res_vld,
    output logic [OUT_W-1:0]       res_int,
    output logic                   flg_invalid,
    output logic                   flg_inexact,
    output logic                   flag_wr,
    output logic                   stat_clr
);
    import f2u_pkg::*;

    localparam int SH_BITS = $clog2(OUT_W);
    localparam int TOP_B   = EXP_W + FRAC_W;

    logic                 d_sign, d_nan, d_inf, d_zero, d_below, d_big;
    logic [FRAC_W:0]      d_sig;
    logic [SH_BITS-1:0]   d_shamt;
    logic [OUT_W-1:0]     a_int;
    logic                 a_sticky;
    logic [OUT_W-1:0]     r_res;
    f2u_flags_t           r_flags;

    f2u_state_e           state_q, state_d;
    logic [OUT_W-1:0]     res_q;
    f2u_flags_t           flags_q;

    f2u_decode #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .OUT_W(OUT_W)) u_dec (
        .op        (src_op),
        .sign      (d_sign),
        .is_nan    (d_nan),
        .is_inf    (d_inf),
        .is_zero   (d_zero),
        .below_one (d_below),
        .too_big   (d_big),
        .sig       (d_sig),
        .shamt     (d_shamt)
    );

    f2u_align #(.FRAC_W(FRAC_W), .OUT_W(OUT_W)) u_aln (
        .sig      (d_sig),
        .shamt    (d_shamt),
        .int_part (a_int),
        .sticky   (a_sticky)
    );

    f2u_resolve #(.OUT_W(OUT_W)) u_res (
        .sign      (d_sign),
        .is_nan    (d_nan),
        .is_inf    (d_inf),
        .is_zero   (d_zero),
        .below_one (d_below),
        .too_big   (d_big),
        .int_part  (a_int),
        .sticky    (a_sticky),
        .result    (r_res),
        .flags     (r_flags)
    );

    // next-state: take on an accepted operand, drain otherwise
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = src_vld ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = src_vld ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q   <= '0;
            flags_q <= '0;
        end else if (src_vld) begin
            res_q   <= r_res;
            flags_q <= r_flags;
        end
    end

    // outputs decoded from the state
    always_comb begin
        res_vld     = 1'b0;
        res_int     = '0;
        flg_invalid = 1'b0;
        flg_inexact = 1'b0;
        flag_wr     = 1'b0;
        stat_clr    = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_EMIT: begin
                res_vld     = 1'b1;
                res_int     = res_q;
                flg_invalid = flags_q.invalid;
                flg_inexact = flags_q.inexact;
                flag_wr     = flags_q.invalid | flags_q.inexact;
                stat_clr    = ~(flags_q.invalid | flags_q.inexact);
            end
            default: ;
        endcase
    end

    p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        src_vld |=> res_vld);

    p_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !src_vld |=> !res_vld);

    p_nan_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (src_vld && (&src_op[TOP_B-1:FRAC_W]) && (|src_op[FRAC_W-1:0]))
        |=> (res_int == '0) && flg_invalid && !flg_inexact);

    p_neg_invalid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (src_vld && src_op[TOP_B] && (|src_op[TOP_B-1:0]))
        |=> (res_int == '0) && flg_invalid && !flg_inexact);

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !res_vld |-> !flag_wr && !stat_clr && !flg_invalid && !flg_inexact);

    p_flag_excl_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> !(flg_invalid && flg_inexact));

    p_one_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> $onehot({flag_wr, stat_clr}));

endmodule

// File: tb/f2u_trunc_conv_test.sv
module f2u_trunc_conv_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        src_vld = 1'b0;
    logic [31:0] src_op = '0;
    logic        res_vld, flg_invalid, flg_inexact, flag_wr, stat_clr;
    logic [31:0] res_int;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    f2u_trunc_conv uut (
        .clk(clk), .rst_n(rst_n), .src_vld(src_vld), .src_op(src_op),
        .res_vld(res_vld), .res_int(res_int), .flg_invalid(flg_invalid),
        .flg_inexact(flg_inexact), .flag_wr(flag_wr), .stat_clr(stat_clr)
    );

    // {operand, result, invalid, inexact}
    localparam int NV = 21;
    localparam logic [65:0] VEC [0:NV-1] = '{
        {32'h00000000, 32'h00000000, 1'b0, 1'b0},  // R5 +0
        {32'h80000000, 32'h00000000, 1'b0, 1'b0},  // R5 -0
        {32'h00000001, 32'h00000000, 1'b0, 1'b1},  // R2 subnormal
        {32'h007FFFFF, 32'h00000000, 1'b0, 1'b1},  // R2 largest subnormal
        {32'h3F000000, 32'h00000000, 1'b0, 1'b1},  // R2 0.5
        {32'h3F800000, 32'h00000001, 1'b0, 1'b0},  // R1 1.0
        {32'h3FC00000, 32'h00000001, 1'b0, 1'b1},  // R2 1.5
        {32'h40490FDB, 32'h00000003, 1'b0, 1'b1},  // R2 pi
        {32'h42C80000, 32'h00000064, 1'b0, 1'b0},  // R1 100
        {32'h4B7FFFFF, 32'h00FFFFFF, 1'b0, 1'b0},  // R1
        {32'h4F000000, 32'h80000000, 1'b0, 1'b0},  // R1 2^31
        {32'h4F7FFFFF, 32'hFFFFFF00, 1'b0, 1'b0},  // R1 2^32-256
        {32'h4F800000, 32'hFFFFFFFF, 1'b1, 1'b0},  // R6 2^32
        {32'h7F7FFFFF, 32'hFFFFFFFF, 1'b1, 1'b0},  // R6 max finite
        {32'h7F800000, 32'hFFFFFFFF, 1'b1, 1'b0},  // R6 +inf
        {32'h7FC00000, 32'h00000000, 1'b1, 1'b0},  // R3 quiet NaN
        {32'h7F800001, 32'h00000000, 1'b1, 1'b0},  // R3 signalling NaN
        {32'hFFC00000, 32'h00000000, 1'b1, 1'b0},  // R3 negative NaN
        {32'hBF000000, 32'h00000000, 1'b1, 1'b0},  // R4 -0.5
        {32'h80000001, 32'h00000000, 1'b1, 1'b0},  // R4 negative subnormal
        {32'hFF800000, 32'h00000000, 1'b1, 1'b0}   // R4 -inf
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // model taken from the requirements
    function automatic logic [33:0] model(input logic [31:0] op);
        logic       s = op[31];
        int         e = int'(op[30:23]);
        logic [22:0] f = op[22:0];
        logic [63:0] w;
        int         ue;
        if (e == 255 && f != 0) return {32'h0, 2'b10};
        if (s && op[30:0] != 0)  return {32'h0, 2'b10};
        if (e == 255)            return {32'hFFFFFFFF, 2'b10};
        if (op[30:0] == 0)       return {32'h0, 2'b00};
        if (e == 0)              return {32'h0, 2'b01};
        ue = e - 127;
        if (ue >= 32)            return {32'hFFFFFFFF, 2'b10};
        if (ue < 0)              return {32'h0, 2'b01};
        w = {40'h0, 1'b1, f} << ue;
        return {w[54:23], 1'b0, (w[22:0] != 0)};
    endfunction

    task automatic check_out(input logic [31:0] op, input logic [31:0] er,
                             input bit einv, input bit einx, input string req);
        chk(res_vld === 1'b1, "R9", "res_vld", {31'h0, res_vld}, 32'h1);
        chk(res_int === er, req, "res_int", res_int, er);
        chk(flg_invalid === einv, req, "invalid", {31'h0, flg_invalid}, {31'h0, einv});
        chk(flg_inexact === einx, req, "inexact", {31'h0, flg_inexact}, {31'h0, einx});
        chk(!(flg_invalid && flg_inexact), "R7", "both flags", {30'h0, flg_invalid, flg_inexact}, 32'h0);
        chk(flag_wr === (einv | einx), "R8", "flag_wr", {31'h0, flag_wr}, {31'h0, einv | einx});
        chk(stat_clr === !(einv | einx), "R8", "stat_clr", {31'h0, stat_clr}, {31'h0, !(einv | einx)});
        if (res_int !== er) $display("  operand %h", op);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] op;
        logic [33:0] m;
        repeat (3) @(negedge clk);
        // reset state R10
        chk(res_vld === 1'b0, "R10", "res_vld in reset", {31'h0, res_vld}, 32'h0);
        chk(flag_wr === 1'b0 && stat_clr === 1'b0, "R8", "status in reset",
            {30'h0, flag_wr, stat_clr}, 32'h0);
        rst_n = 1'b1;

        // table, streamed back to back (R9)
        src_vld = 1'b1;
        src_op  = VEC[0][65:34];
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            check_out(VEC[i][65:34], VEC[i][33:2], VEC[i][1], VEC[i][0], "R1..R6 table");
            if (i + 1 < NV) src_op = VEC[i+1][65:34];
        end
        src_vld = 1'b0;
        @(negedge clk);
        chk(res_vld === 1'b0, "R9", "drain after stream", {31'h0, res_vld}, 32'h0);
        chk(flag_wr === 1'b0 && stat_clr === 1'b0, "R8", "idle status",
            {30'h0, flag_wr, stat_clr}, 32'h0);

        // directed: -100 then 100 separated by an idle cycle
        src_vld = 1'b1; src_op = 32'hC2C80000;
        @(negedge clk);
        check_out(32'hC2C80000, 32'h0, 1'b1, 1'b0, "R4 -100");
        src_vld = 1'b0;
        @(negedge clk);
        chk(res_vld === 1'b0, "R9", "gap", {31'h0, res_vld}, 32'h0);
        src_vld = 1'b1; src_op = 32'h42C80000;
        @(negedge clk);
        check_out(32'h42C80000, 32'h64, 1'b0, 1'b0, "R1 100");

        // random operands around the interesting exponents
        for (int n = 0; n < 400; n++) begin
            op = {1'($urandom), 8'(100 + ($urandom % 70)), 23'($urandom)};
            if (n % 9 == 0) op[22:0] = '0;
            src_op = op;
            @(negedge clk);
            m = model(op);
            check_out(op, m[33:2], m[1], m[0], (m[1] ? "R6/R4 random" : "R1/R2 random"));
        end

        // reset while an operand is offered: R10
        src_op = 32'h3F800000;
        src_vld = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        chk(res_vld === 1'b0, "R10", "reset beats accept", {31'h0, res_vld}, 32'h0);
        rst_n = 1'b1;
        src_vld = 1'b0;
        @(negedge clk);
        chk(res_vld === 1'b0, "R10", "idle after reset", {31'h0, res_vld}, 32'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule